// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers up to 32 active-high, level-sensitive interrupt requests from on-board peripherals and fans them out to four output lines. Two lines carry normal interrupts, one per processor core. The other two carry machine-check requests, again one per core. Each line has its own 32-bit enable mask. A line is high for as long as any request that its mask enables is high.

Software reaches the block through a small word-wide register port. Every access is a full 32-bit word, and the two low address bits are ignored. Software reads the synchronized request levels from a status word. It reads and writes the four masks, so a single mask bit can be changed by read-modify-write. Requests are never latched and there is nothing to acknowledge. A line falls only when the peripheral withdraws its request or software clears the mask bit. Nothing stops one request from being enabled in several masks, and in that case every enabled line rises at the same time.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four masks are cleared to zero. After reset, all four output lines are low and `bus_rdata` is zero.
- R2: Each request passes through two flip-flops before it reaches the status word. A change on `irq_in` that is present at one rising edge shows up in the status word after the second rising edge.
- R3: The status word is at word offset 0x00. Bits 31 to 17 and bit 6 are unimplemented and always read as zero. Their requests can never raise an output line.
- R4: The four masks are readable and writable as full words at these offsets: core-0 interrupt at 0x10, core-1 interrupt at 0x14, core-0 machine check at 0x18, core-1 machine check at 0x1C.
- R5: Each output line is registered. One rising edge after the status word or its mask changes, the line equals the OR of (status AND mask). The lines are `irq_core_o[0]`, `irq_core_o[1]`, `mchk_core_o[0]` and `mchk_core_o[1]`, in the same order as the masks in R4.
- R6: The output lines do not exclude one another. A request that is enabled in several masks raises every one of those lines together.
- R7: Requests are not latched. When a request falls, any line it alone was holding falls three rising edges later.
- R8: Writes to offset 0x00, or to any offset other than the four mask offsets, change no register. Reads of unmapped offsets (0x04, 0x08, 0x0C) return zero.
- R9: A read strobe (`bus_sel`=1, `bus_wr`=0) at a rising edge loads `bus_rdata` with the addressed word. `bus_rdata` then holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 32 | Level requests from peripherals, active high, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte offset within the 0x20-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_core_o | output | 2 | Interrupt line for core 0 (bit 0) and core 1 (bit 1) |
| mchk_core_o | output | 2 | Machine-check line for core 0 (bit 0) and core 1 (bit 1) |

## Verification
Two functions can land on the same rising edge: a mask write, and a request edge travelling down the synchronizer. The bench provokes this by raising a request in the same cycle that it writes the enabling mask bit. It then judges the cycle in which the line must rise, and it checks that the line is still low in the cycle before. It does the same in reverse, dropping a request while clearing a mask bit. A read of the status word is also made while a request edge is still inside the synchronizer. That read must return the level from before the edge.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt aggregator.
// Assumes the four targets are ordered by mask offset.
package irq_agg_pkg;
    localparam int unsigned NUM_TGT   = 4;
    localparam int unsigned TGT_INT0  = 0;
    localparam int unsigned TGT_INT1  = 1;
    localparam int unsigned TGT_MCHK0 = 2;
    localparam int unsigned TGT_MCHK1 = 3;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer feeding the status word.
// Assumes each request is a slow level; unimplemented bits are tied to zero.
module irq_sync #(
    parameter int unsigned W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stat_q;

    // Two capture stages; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stat_q <= '0;
        end else begin
            meta_q <= raw_i & IMPL_MASK;
            stat_q <= meta_q;
        end
    end

    assign status_o = stat_q;

    assert_status_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (status_o == ($past(raw_i, 2) & IMPL_MASK)));

    assert_resv_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~IMPL_MASK) == '0);
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
// Bank of per-target enable masks, one word each at consecutive word offsets.
// Assumes word accesses only; the low two address bits are ignored.
module irq_mask_bank #(
    parameter int unsigned W         = 32,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned NT        = 4,
    parameter int unsigned MASK_BASE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [W-1:0]         wdata_i,
    output logic [NT-1:0][W-1:0] mask_o
);
    localparam int unsigned WORD_W    = ADDR_W - 2;
    localparam int unsigned BASE_WORD = MASK_BASE / 4;

    logic [WORD_W-1:0] word_idx;
    logic [NT-1:0]     hit;

    assign word_idx = addr_i[ADDR_W-1:2];

    for (genvar t = 0; t < NT; t++) begin : g_mask
        localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(BASE_WORD + t);
        logic [W-1:0] mask_q;

        assign hit[t] = wr_en_i && (word_idx == MY_WORD);

        // Load the mask on a matching write; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      mask_q <= '0;
            else if (hit[t]) mask_q <= wdata_i;
        end

        assign mask_o[t] = mask_q;

        assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && (addr_i[ADDR_W-1:2] == MY_WORD)) |=> (mask_o[t] == $past(wdata_i)));

        assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && (addr_i[ADDR_W-1:2] == MY_WORD)) |=> $stable(mask_o[t]));

        assert_mask_reset_R1: assert property (@(posedge clk)
            !rst_n |=> (mask_o[t] == '0));
    end

    assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/irq_out_stage.sv
`timescale 1ns/1ps
// Registered OR-reduction of (status AND mask) for each output line.
// Assumes levels only: nothing is latched, so a line follows its sources.
module irq_out_stage #(
    parameter int unsigned W  = 32,
    parameter int unsigned NT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         status_i,
    input  logic [NT-1:0][W-1:0] mask_i,
    output logic [NT-1:0]        line_o
);
    for (genvar t = 0; t < NT; t++) begin : g_line
        logic line_q;

        // One flop per line holds the gated OR.
        always_ff @(posedge clk) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= |(status_i & mask_i[t]);
        end

        assign line_o[t] = line_q;

        assert_line_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (line_o[t] == (($past(status_i) & $past(mask_i[t])) != '0)));

        assert_line_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_i & mask_i[t]) == '0) |=> !line_o[t]);
    end
endmodule

// File: rtl/irq_reg_read.sv
`timescale 1ns/1ps
// Read-data register: the status word, a mask, or zero for unmapped offsets.
// Assumes the status word sits at word 0 and the masks start at MASK_BASE.
module irq_reg_read #(
    parameter int unsigned W         = 32,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned NT        = 4,
    parameter int unsigned MASK_BASE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [W-1:0]         status_i,
    input  logic [NT-1:0][W-1:0] mask_i,
    output logic [W-1:0]         rdata_o
);
    localparam int unsigned WORD_W    = ADDR_W - 2;
    localparam int unsigned BASE_WORD = MASK_BASE / 4;

    logic [WORD_W-1:0] word_idx;
    logic [W-1:0]      sel_word;
    logic              mapped;
    logic [W-1:0]      rdata_q;

    assign word_idx = addr_i[ADDR_W-1:2];

    // Pick the addressed word; unmapped offsets give zero.
    always_comb begin
        sel_word = '0;
        mapped   = 1'b0;
        if (word_idx == '0) begin
            sel_word = status_i;
            mapped   = 1'b1;
        end
        for (int t = 0; t < int'(NT); t++) begin
            if (word_idx == WORD_W'(BASE_WORD + t)) begin
                sel_word = mask_i[t];
                mapped   = 1'b1;
            end
        end
    end

    // Capture on a read strobe; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= sel_word;
    end

    assign rdata_o = rdata_q;

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !mapped) |=> (rdata_o == '0));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

    assert_status_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i[ADDR_W-1:2] == '0)) |=> (rdata_o == $past(status_i)));
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
// Top of the level interrupt aggregator: synchronizer, mask bank,
// output stage and read port. Assumes word-only bus accesses.
module irq_aggregator #(
    parameter int unsigned  IN_W      = 32,
    parameter int unsigned  ADDR_W    = 5,
    parameter int unsigned  MASK_BASE = 16,
    parameter logic [31:0]  IMPL_MASK = 32'h0001_FFBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [IN_W-1:0]   bus_wdata,
    output logic [IN_W-1:0]   bus_rdata,
    output logic [1:0]        irq_core_o,
    output logic [1:0]        mchk_core_o
);
    import irq_agg_pkg::*;

    logic [IN_W-1:0]              status;
    logic [NUM_TGT-1:0][IN_W-1:0] masks;
    logic [NUM_TGT-1:0]           lines;
    logic                         wr_en;
    logic                         rd_en;

    assign wr_en = bus_sel &  bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    irq_sync #(.W(IN_W), .IMPL_MASK(IMPL_MASK[IN_W-1:0])) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_in), .status_o(status)
    );

    irq_mask_bank #(.W(IN_W), .ADDR_W(ADDR_W), .NT(NUM_TGT), .MASK_BASE(MASK_BASE)) u_masks (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .mask_o(masks)
    );

    irq_out_stage #(.W(IN_W), .NT(NUM_TGT)) u_out (
        .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(masks), .line_o(lines)
    );

    irq_reg_read #(.W(IN_W), .ADDR_W(ADDR_W), .NT(NUM_TGT), .MASK_BASE(MASK_BASE)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .addr_i(bus_addr),
        .status_i(status), .mask_i(masks), .rdata_o(bus_rdata)
    );

    assign irq_core_o  = {lines[TGT_INT1],  lines[TGT_INT0]};
    assign mchk_core_o = {lines[TGT_MCHK1], lines[TGT_MCHK0]};

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> ((irq_core_o == 2'b00) && (mchk_core_o == 2'b00) && (bus_rdata == '0)));

    assert_shared_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & masks[TGT_INT0] & masks[TGT_MCHK1]) != '0) |=> (irq_core_o[0] && mchk_core_o[1]));
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    localparam logic [31:0] IMPL = 32'h0001_FFBF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_core_o;
    logic [1:0]  mchk_core_o;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] m [4];

    always #2.5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_core_o(irq_core_o), .mchk_core_o(mchk_core_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] lines_now();
        return {28'd0, mchk_core_o, irq_core_o};
    endfunction

    function automatic logic [31:0] exp_lines(input logic [31:0] req);
        logic [31:0] s = req & IMPL;
        return {28'd0, |(s & m[3]), |(s & m[2]), |(s & m[1]), |(s & m[0])};
    endfunction

    task automatic set_masks(input logic [31:0] a, b, c, d);
        m[0] = a; m[1] = b; m[2] = c; m[3] = d;
        bus_write(5'h10, a); bus_write(5'h14, b);
        bus_write(5'h18, c); bus_write(5'h1C, d);
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] pat;
        for (int t = 0; t < 4; t++) m[t] = '0;

        // R1: reset with requests active
        irq_in = 32'hFFFF_FFFF;
        wait_n(4);
        rst_n = 1'b1;
        check("R1 lines after reset", lines_now(), 32'd0);
        check("R1 rdata after reset", bus_rdata, 32'd0);
        for (int t = 0; t < 4; t++) begin
            bus_read(5'(16 + 4 * t), rd);
            check("R1 mask reset", rd, 32'd0);
        end
        wait_n(2);
        bus_read(5'h00, rd);
        check("R3 reserved bits zero", rd, IMPL);
        check("R1 masks zero keep lines low", lines_now(), 32'd0);
        irq_in = '0;
        wait_n(3);

        // R4: mask read/write, ignoring low address bits
        set_masks(32'h5555_5555, 32'hAAAA_AAAA, 32'h0000_FF00, 32'hFFFF_FFFF);
        for (int t = 0; t < 4; t++) begin
            bus_read(5'(16 + 4 * t + 3), rd);
            check("R4 mask readback", rd, m[t]);
        end

        // R8: writes to status and unmapped offsets ignored; unmapped reads zero
        for (int a = 0; a < 4; a++) begin
            bus_write(5'(4 * a), 32'h1234_5678);
            bus_read(5'(4 * a), rd);
            check("R8 status/unmapped read", rd, (a == 0) ? 32'd0 : 32'd0);
        end
        for (int t = 0; t < 4; t++) begin
            bus_read(5'(16 + 4 * t), rd);
            check("R8 mask untouched", rd, m[t]);
        end

        // R2 R3 R5 R7: sweep every request bit
        for (int i = 0; i < 32; i++) begin
            pat = 32'd1 << i;
            irq_in = pat;
            wait_n(2);
            check("R5 line not early", lines_now(), 32'd0);
            wait_n(1);
            check("R5 line from single request", lines_now(), exp_lines(pat));
            bus_read(5'h00, rd);
            check("R2 R3 status word", rd, pat & IMPL);
            irq_in = '0;
            wait_n(2);
            check("R7 line holds before drop", lines_now(), exp_lines(pat));
            wait_n(1);
            check("R7 line falls with request", lines_now(), 32'd0);
        end

        // R5 R6: multi-bit patterns
        for (int k = 0; k < 16; k++) begin
            pat = (32'h9E37_79B9 * (k + 1)) ^ (32'h0000_0101 << k);
            irq_in = pat;
            wait_n(3);
            check("R5 R6 multi pattern", lines_now(), exp_lines(pat));
        end
        irq_in = '0;
        wait_n(3);

        // R6: one request enabled everywhere raises all four
        set_masks(32'h0000_0020, 32'h0000_0020, 32'h0000_0020, 32'h0000_0020);
        irq_in = 32'h0000_0020;
        wait_n(3);
        check("R6 all four lines", lines_now(), 32'h0000_000F);
        irq_in = '0;
        wait_n(3);

        // R2: status read while an edge is still in the synchronizer
        irq_in = 32'h0000_0001;
        bus_read(5'h00, rd);
        check("R2 status before edge arrives", rd, 32'd0);
        wait_n(2);
        irq_in = '0;
        wait_n(3);

        // R5: mask write and request edge on the same edge
        set_masks('0, '0, '0, '0);
        irq_in = 32'h0000_0008;
        m[0] = 32'h0000_0008;
        bus_write(5'h10, 32'h0000_0008);
        wait_n(1);
        check("R5 same-cycle not yet", lines_now(), 32'd0);
        wait_n(1);
        check("R5 same-cycle rises", lines_now(), 32'h0000_0001);
        // R5: clearing the mask drops the line one edge later
        m[0] = '0;
        bus_write(5'h10, 32'd0);
        check("R5 mask clear not yet", lines_now(), 32'h0000_0001);
        wait_n(1);
        check("R5 mask clear drops line", lines_now(), 32'd0);

        // R9: rdata holds without a read strobe
        bus_write(5'h14, 32'hCAFE_F00D);
        bus_read(5'h14, rd);
        bus_write(5'h14, 32'h0);
        wait_n(2);
        check("R9 rdata hold", bus_rdata, 32'hCAFE_F00D);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule